// File: doc/BRIEF.md
# Byte DMA Engine with Boundary Stop

This block moves single bytes between a system memory port and a controller's byte buffer. Software loads a 64-bit start address as two 32-bit halves, picks a direction and sets a two-bit mode field to the run value. The engine then copies one byte per memory transaction. Toward memory it drains the buffer until the buffer is empty. From memory it fills the buffer until the buffer is full. The address steps by one for each byte that completes.

An optional boundary check pauses the transfer at a power-of-two address boundary. The boundary is 4 KiB times a power of two chosen by a three-bit size field. When the last byte below the boundary completes, the engine stops and raises a one-cycle event for the interrupt logic. It stays stopped until software writes the low address register again, which also reloads the address and restarts the transfer.

The register write port and the combinational read-back port carry only this block's own settings. The memory side is a plain request/accept port followed by a response strobe. Only one transaction is open at any time.

Top module: `bdma_engine`

## Requirements
- R1: After an asynchronous reset (rst_n low) the block raises no memory request, no buffer pop, no buffer push and no dma_event, and every register reads back as zero.
- R2: The working address is the 64-bit value {high register, low register}. A write to either half (select 2 = high, select 1 = low) reloads it, and the next request uses that value. Carries out of the low half propagate into the high half as bytes advance.
- R3: A transfer starts only while the mode field at command bits 27:26 (select 0) holds 2. The values 0, 1 and 3 start nothing.
- R4: With to_memory high, each byte is popped from the buffer and written (mem_req_write = 1) at the working address with the popped value, in buffer order. No request starts while the buffer is empty.
- R5: With to_memory low, each byte is read from memory (mem_req_write = 0) and the response byte is pushed into the buffer in the cycle the response arrives. No request starts while buf_push_ready is low.
- R6: Only one transaction is open at a time. The address advances by one when the response arrives, so successive requests without an address write use consecutive addresses.
- R7: In the boundary register (select 3), bit 3 enables the check and bits 2:0 hold N. When the check is enabled and a byte completes at an address whose low 12+N bits are all ones, dma_event pulses for one cycle and the engine blocks. With bit 3 clear the engine never stops at a boundary.
- R8: A blocked engine starts no request until the low address register is written. A write to the high register reloads the address but leaves the engine blocked.
- R9: A pending request keeps valid, direction, address and write data unchanged until mem_req_ready accepts it.
- R10: The command register reads back only its mode field at bits 27:26. The boundary register reads back only bits 3:0. Both address registers read back all 32 bits. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write select: 0 command, 1 low address, 2 high address, 3 boundary |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Read select, same encoding as the write select |
| reg_rd_data | output | 32 | Combinational read-back of the selected register |
| to_memory | input | 1 | 1: buffer to memory, 0: memory to buffer |
| buf_pop_valid | input | 1 | Buffer holds at least one byte |
| buf_pop_data | input | 8 | Byte at the head of the buffer |
| buf_pop_ready | output | 1 | Byte taken from the buffer at this edge |
| buf_push_ready | input | 1 | Buffer has room for a byte |
| buf_push_valid | output | 1 | Byte pushed into the buffer at this edge |
| buf_push_data | output | 8 | Byte being pushed |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request at this edge |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Response or write acknowledge |
| mem_rsp_rdata | input | 8 | Read response byte |
| dma_event | output | 1 | One-cycle pulse when a boundary stop occurs |

## Verification
A byte that starts at edge T shows as mem_req_valid after T. For a buffer-to-memory byte, buf_pop_ready is high in the cycle before T and the pop takes effect at T. The address step, any push and the blocked state all take effect at the edge where mem_rsp_valid is seen. dma_event is high for the cycle after that edge. Register read-back is combinational, and a register write takes effect at the next edge. The bench changes inputs at the falling edge and samples one time unit later, so each result is read half a cycle after the edge that made it and before the next edge. Each transaction is checked when the bench accepts it: its address, direction, data and held-stable request.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

   typedef enum logic [1:0] {
      SEL_CMD     = 2'd0,
      SEL_ADDR_LO = 2'd1,
      SEL_ADDR_HI = 2'd2,
      SEL_BOUND   = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } seq_state_e;

endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
   import bdma_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int MODE_LSB = 26,
   parameter int MODE_W   = 2,
   parameter int BND_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [1:0]           rd_sel,
   output logic [REG_W-1:0]     rd_data,
   output logic [MODE_W-1:0]    mode,
   output logic [BND_W-1:0]     bnd,
   output logic [2*REG_W-1:0]   load_addr,
   output logic                 lo_wr,
   output logic                 addr_wr
);

   logic [REG_W-1:0]  lo_q, hi_q;
   logic [MODE_W-1:0] mode_q;
   logic [BND_W-1:0]  bnd_q;
   logic              hi_wr;

   assign lo_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_ADDR_LO);
   assign hi_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_ADDR_HI);
   assign addr_wr = lo_wr || hi_wr;

   // value the working address takes on the edge of an address write
   assign load_addr = {hi_wr ? wr_data : hi_q, lo_wr ? wr_data : lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         mode_q <= '0;
         bnd_q  <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            SEL_CMD:     mode_q <= wr_data[MODE_LSB +: MODE_W];
            SEL_ADDR_LO: lo_q   <= wr_data;
            SEL_ADDR_HI: hi_q   <= wr_data;
            SEL_BOUND:   bnd_q  <= wr_data[BND_W-1:0];
            default:     bnd_q  <= bnd_q;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (reg_sel_e'(rd_sel))
         SEL_CMD:     rd_data[MODE_LSB +: MODE_W] = mode_q;
         SEL_ADDR_LO: rd_data = lo_q;
         SEL_ADDR_HI: rd_data = hi_q;
         SEL_BOUND:   rd_data[BND_W-1:0] = bnd_q;
         default:     rd_data = '0;
      endcase
   end

   assign mode = mode_q;
   assign bnd  = bnd_q;

endmodule

// File: rtl/bdma_bound.sv
module bdma_bound #(
   parameter int ADDR_W     = 64,
   parameter int BASE_SHIFT = 12,
   parameter int SIZE_W     = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   input  logic [SIZE_W-1:0] size,
   output logic              hit
);

   localparam int SPAN = BASE_SHIFT + (1 << SIZE_W) - 1;

   logic [SPAN-1:0] care;

   // care[i] marks the address bits that must all be one for a stop
   for (genvar i = 0; i < SPAN; i++) begin : g_care
      if (i < BASE_SHIFT) begin : g_fixed
         assign care[i] = 1'b1;
      end else begin : g_sized
         assign care[i] = (32'(size) > (i - BASE_SHIFT));
      end
   end

   assign hit = en && (&(addr[SPAN-1:0] | ~care));

endmodule

// File: rtl/bdma_seq.sv
module bdma_seq
   import bdma_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int DATA_W   = 8,
   parameter int MODE_W   = 2,
   parameter int MODE_RUN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              unblock,
   input  logic              hit,
   input  logic              to_memory,
   input  logic              buf_pop_valid,
   input  logic [DATA_W-1:0] buf_pop_data,
   output logic              buf_pop_ready,
   input  logic              buf_push_ready,
   output logic              buf_push_valid,
   output logic [DATA_W-1:0] buf_push_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              dma_event
);

   seq_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              wr_q, blocked_q, event_q;
   logic              run, start_out, start_in, done;

   assign run       = (mode == MODE_W'(MODE_RUN)) && !blocked_q;
   assign start_out = (st_q == ST_IDLE) && run && to_memory && buf_pop_valid;
   assign start_in  = (st_q == ST_IDLE) && run && !to_memory && buf_push_ready;
   assign done      = (st_q == ST_WAIT) && mem_rsp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         data_q <= '0;
         wr_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_out) begin
                  data_q <= buf_pop_data;
                  wr_q   <= 1'b1;
                  st_q   <= ST_REQ;
               end else if (start_in) begin
                  wr_q   <= 1'b0;
                  st_q   <= ST_REQ;
               end
            end
            ST_REQ:  if (mem_req_ready) st_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // an address write takes priority over the per-byte step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= load_addr;
      else if (done) addr_q <= addr_q + ADDR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blocked_q <= 1'b0;
         event_q   <= 1'b0;
      end else begin
         event_q <= done && hit;
         if (unblock)          blocked_q <= 1'b0;
         else if (done && hit) blocked_q <= 1'b1;
      end
   end

   assign buf_pop_ready  = start_out;
   assign buf_push_valid = done && !wr_q;
   assign buf_push_data  = mem_rsp_rdata;
   assign mem_req_valid  = (st_q == ST_REQ);
   assign mem_req_write  = wr_q;
   assign mem_req_addr   = addr_q;
   assign mem_req_wdata  = data_q;
   assign cur_addr       = addr_q;
   assign dma_event      = event_q;

endmodule

// File: rtl/bdma_engine.sv
module bdma_engine #(
   parameter int REG_W      = 32,
   parameter int DATA_W     = 8,
   parameter int MODE_LSB   = 26,
   parameter int MODE_W     = 2,
   parameter int MODE_RUN   = 2,
   parameter int BND_SIZE_W = 3,
   parameter int BASE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_sel,
   input  logic [REG_W-1:0]  reg_wr_data,
   input  logic [1:0]        reg_rd_sel,
   output logic [REG_W-1:0]  reg_rd_data,
   input  logic              to_memory,
   input  logic              buf_pop_valid,
   input  logic [DATA_W-1:0] buf_pop_data,
   output logic              buf_pop_ready,
   input  logic              buf_push_ready,
   output logic              buf_push_valid,
   output logic [DATA_W-1:0] buf_push_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [2*REG_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic              dma_event
);

   localparam int ADDR_W = 2 * REG_W;
   localparam int BND_W  = BND_SIZE_W + 1;

   if (MODE_LSB + MODE_W > REG_W) begin : g_bad_mode
      $error("mode field does not fit the command register");
   end
   if (BASE_SHIFT + (1 << BND_SIZE_W) - 1 > ADDR_W) begin : g_bad_bound
      $error("largest boundary mask exceeds the address width");
   end
   if (MODE_RUN >= (1 << MODE_W)) begin : g_bad_run
      $error("run value does not fit the mode field");
   end

   logic [MODE_W-1:0] cfg_mode;
   logic [BND_W-1:0]  cfg_bnd;
   logic [ADDR_W-1:0] cfg_load_addr;
   logic              cfg_lo_wr, cfg_addr_wr;
   logic [ADDR_W-1:0] cur_addr;
   logic              bnd_hit;

   bdma_regs #(
      .REG_W(REG_W), .MODE_LSB(MODE_LSB), .MODE_W(MODE_W), .BND_W(BND_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
      .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
      .mode(cfg_mode), .bnd(cfg_bnd), .load_addr(cfg_load_addr),
      .lo_wr(cfg_lo_wr), .addr_wr(cfg_addr_wr)
   );

   bdma_bound #(
      .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT), .SIZE_W(BND_SIZE_W)
   ) u_bound (
      .addr(cur_addr), .en(cfg_bnd[BND_SIZE_W]),
      .size(cfg_bnd[BND_SIZE_W-1:0]), .hit(bnd_hit)
   );

   bdma_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .MODE_RUN(MODE_RUN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .mode(cfg_mode), .load(cfg_addr_wr), .load_addr(cfg_load_addr),
      .unblock(cfg_lo_wr), .hit(bnd_hit), .to_memory(to_memory),
      .buf_pop_valid(buf_pop_valid), .buf_pop_data(buf_pop_data),
      .buf_pop_ready(buf_pop_ready), .buf_push_ready(buf_push_ready),
      .buf_push_valid(buf_push_valid), .buf_push_data(buf_push_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .cur_addr(cur_addr),
      .dma_event(dma_event)
   );

endmodule

// File: rtl/bdma_checker.sv
module bdma_checker #(
   parameter int ADDR_W   = 64,
   parameter int DATA_W   = 8,
   parameter int MODE_W   = 2,
   parameter int MODE_RUN = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] mode,
   input logic              lo_wr,
   input logic              addr_wr,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_wdata,
   input logic              mem_rsp_valid,
   input logic              buf_pop_valid,
   input logic              buf_pop_ready,
   input logic              buf_push_ready,
   input logic              buf_push_valid,
   input logic              dma_event
);

   logic              acc;
   logic              open_q, have_last_q, fresh_q, blk_q;
   logic [ADDR_W-1:0] last_q;

   assign acc = mem_req_valid && mem_req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q      <= 1'b0;
         have_last_q <= 1'b0;
         fresh_q     <= 1'b0;
         last_q      <= '0;
         blk_q       <= 1'b0;
      end else begin
         if (acc)                open_q <= 1'b1;
         else if (mem_rsp_valid) open_q <= 1'b0;
         if (acc) begin
            last_q      <= mem_req_addr;
            have_last_q <= 1'b1;
            fresh_q     <= addr_wr;
         end else if (addr_wr) begin
            fresh_q     <= 1'b1;
         end
         if (lo_wr)          blk_q <= 1'b0;
         else if (dma_event) blk_q <= 1'b1;
      end
   end

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
       && $stable(mem_req_write)));

   p_single_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> !mem_req_valid);

   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && have_last_q && !fresh_q) |-> (mem_req_addr == last_q + ADDR_W'(1)));

   p_event_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_event |=> !dma_event);

   p_stay_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      blk_q |-> !mem_req_valid);

   p_mode_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> ($past(mode) == MODE_W'(MODE_RUN)));

   p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      buf_pop_ready |-> buf_pop_valid);

   p_read_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req_valid) && !mem_req_write) |-> $past(buf_push_ready));

   p_push_on_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_push_valid |-> mem_rsp_valid);

endmodule

bind bdma_engine bdma_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .MODE_RUN(MODE_RUN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .lo_wr(cfg_lo_wr),
   .addr_wr(cfg_addr_wr), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
   .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
   .mem_rsp_valid(mem_rsp_valid), .buf_pop_valid(buf_pop_valid),
   .buf_pop_ready(buf_pop_ready), .buf_push_ready(buf_push_ready),
   .buf_push_valid(buf_push_valid), .dma_event(dma_event)
);

// File: tb/sim_bdma_engine.sv
module sim_bdma_engine;

   localparam int CLK_PERIOD = 10;

   logic        clk, rst_n;
   logic        reg_wr_en;
   logic [1:0]  reg_wr_sel, reg_rd_sel;
   logic [31:0] reg_wr_data, reg_rd_data;
   logic        to_memory;
   logic        buf_pop_valid, buf_pop_ready, buf_push_ready, buf_push_valid;
   logic [7:0]  buf_pop_data, buf_push_data;
   logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
   logic [63:0] mem_req_addr;
   logic [7:0]  mem_req_wdata, mem_rsp_rdata;
   logic        dma_event;

   bdma_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
      .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .to_memory(to_memory), .buf_pop_valid(buf_pop_valid), .buf_pop_data(buf_pop_data),
      .buf_pop_ready(buf_pop_ready), .buf_push_ready(buf_push_ready),
      .buf_push_valid(buf_push_valid), .buf_push_data(buf_push_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .dma_event(dma_event)
   );

   int n_chk = 0, n_fail = 0;
   int n_req = 0, n_ev = 0;
   logic [7:0]  q [0:63];
   int          q_cnt = 0, q_cap = 64;
   logic [63:0] exp_addr = '0, pend_addr = '0, hold_addr = '0;
   logic [31:0] lo_sh = '0, hi_sh = '0;
   logic        pend_wr = 1'b0, pop_pend = 1'b0, push_pend = 1'b0;
   logic        rnd_ready = 1'b0, hold_flag = 1'b0;
   logic [7:0]  push_byte = '0, last_pop = '0, hold_data = '0;
   int          rsp_timer = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] fdat(input logic [63:0] a);
      return a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'hA5;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // buffer and memory model
   initial begin
      forever begin
         @(negedge clk);
         if (pop_pend) begin
            last_pop = q[0];
            for (int k = 0; k < 63; k++) q[k] = q[k+1];
            q_cnt--;
         end
         if (push_pend) begin
            q[q_cnt] = push_byte;
            q_cnt++;
         end
         pop_pend = 1'b0;
         push_pend = 1'b0;
         mem_rsp_valid = 1'b0;
         if (rsp_timer > 0) begin
            rsp_timer--;
            if (rsp_timer == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = pend_wr ? 8'h00 : fdat(pend_addr);
               exp_addr = pend_addr + 64'd1;
            end
         end
         mem_req_ready  = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
         buf_pop_valid  = (q_cnt > 0);
         buf_pop_data   = q[0];
         buf_push_ready = (q_cnt < q_cap);
         #1;
         if (hold_flag) begin
            chk(mem_req_valid && mem_req_addr == hold_addr && mem_req_wdata == hold_data,
                "R9 request held", mem_req_addr, hold_addr);
         end
         hold_flag = mem_req_valid && !mem_req_ready;
         hold_addr = mem_req_addr;
         hold_data = mem_req_wdata;
         if (buf_pop_ready) pop_pend = 1'b1;
         if (buf_push_valid) begin
            push_pend = 1'b1;
            push_byte = buf_push_data;
            chk(buf_push_data == fdat(pend_addr), "R5 pushed byte", buf_push_data,
                fdat(pend_addr));
         end
         if (dma_event) n_ev++;
         if (mem_req_valid && mem_req_ready) begin
            n_req++;
            chk(mem_req_addr == exp_addr, "R2 R6 request address", mem_req_addr, exp_addr);
            chk(mem_req_write == to_memory, "R4 R5 direction", mem_req_write, to_memory);
            if (mem_req_write)
               chk(mem_req_wdata == last_pop, "R4 written byte", mem_req_wdata, last_pop);
            pend_addr = mem_req_addr;
            pend_wr   = mem_req_write;
            rsp_timer = rnd_ready ? 1 + int'($urandom % 3) : 1;
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      if (sel == 2'd1) lo_sh = d;
      if (sel == 2'd2) hi_sh = d;
      if (sel == 2'd1 || sel == 2'd2) exp_addr = {hi_sh, lo_sh};
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] sel, input logic [31:0] expv, input string tag);
      reg_rd_sel = sel;
      #1;
      chk(reg_rd_data == expv, tag, reg_rd_data, expv);
   endtask

   task automatic preload(input int n, input int seed);
      for (int i = 0; i < n; i++) q[i] = 8'(seed * 37 + i * 11);
      q_cnt = n;
   endtask

   task automatic setup(input logic [31:0] hi, input logic [31:0] lo,
                        input logic [3:0] bnd, input logic dir);
      wr_reg(2'd0, 32'h0);
      wr_reg(2'd3, {28'h0, bnd});
      wr_reg(2'd2, hi);
      wr_reg(2'd1, lo);
      to_memory = dir;
   endtask

   localparam logic [31:0] RUN = 32'h0800_0000;

   initial begin : main
      int base_req, base_ev, exp_n;
      logic exp_blk;
      rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
      reg_rd_sel = '0; to_memory = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
      mem_req_ready = 1'b1; buf_pop_valid = 1'b0; buf_pop_data = '0; buf_push_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(1);
      // R1 reset state
      chk(!mem_req_valid && !buf_pop_ready && !buf_push_valid && !dma_event,
          "R1 outputs idle", {mem_req_valid, buf_pop_ready, buf_push_valid, dma_event}, 0);
      for (int s = 0; s < 4; s++) rd_chk(2'(s), 32'h0, "R1 register zero");

      // R10 read-back masking
      wr_reg(2'd3, 32'hFFFF_FFF5);
      wr_reg(2'd0, 32'hFFFF_FFFF);
      wr_reg(2'd1, 32'hDEAD_BEEF);
      wr_reg(2'd2, 32'h1234_5678);
      #2;
      rd_chk(2'd3, 32'h0000_0005, "R10 boundary bits");
      rd_chk(2'd0, 32'h0C00_0000, "R10 command bits");
      rd_chk(2'd1, 32'hDEAD_BEEF, "R10 low address");
      rd_chk(2'd2, 32'h1234_5678, "R10 high address");

      // R3 mode gate, then R4 drain
      wr_reg(2'd3, 32'h0); wr_reg(2'd2, 32'h0); wr_reg(2'd1, 32'h100);
      to_memory = 1'b1;
      preload(4, 1);
      base_req = n_req;
      wr_reg(2'd0, 32'h0C00_0000); wait_cyc(30);
      chk(n_req == base_req, "R3 mode 3 idle", n_req - base_req, 0);
      wr_reg(2'd0, 32'h0400_0000); wait_cyc(30);
      chk(n_req == base_req, "R3 mode 1 idle", n_req - base_req, 0);
      wr_reg(2'd0, 32'h0); wait_cyc(30);
      chk(n_req == base_req, "R3 mode 0 idle", n_req - base_req, 0);
      wr_reg(2'd0, RUN); wait_cyc(60);
      chk(n_req - base_req == 4, "R4 all bytes moved", n_req - base_req, 4);
      chk(q_cnt == 0, "R4 buffer drained", q_cnt, 0);
      wait_cyc(20);
      chk(n_req - base_req == 4, "R4 stops when empty", n_req - base_req, 4);

      // R5 fill from memory until full
      setup(32'h1, 32'h2000_0040, 4'h0, 1'b0);
      q_cnt = 0; q_cap = 5; base_req = n_req;
      wr_reg(2'd0, RUN); wait_cyc(80);
      chk(n_req - base_req == 5, "R5 fills to capacity", n_req - base_req, 5);
      chk(q_cnt == 5, "R5 buffer full", q_cnt, 5);
      for (int i = 0; i < 5; i++)
         chk(q[i] == fdat(64'h1_2000_0040 + 64'(i)), "R5 buffer content", q[i],
             fdat(64'h1_2000_0040 + 64'(i)));
      q_cap = 64;

      // R2 carry into the high half
      setup(32'h5, 32'hFFFF_FFFE, 4'h0, 1'b1);
      q_cnt = 0; preload(4, 2); base_req = n_req;
      wr_reg(2'd0, RUN); wait_cyc(60);
      chk(n_req - base_req == 4, "R2 carry run length", n_req - base_req, 4);

      // R7 stop at 4 KiB, R8 hold and restart
      setup(32'h0, 32'h0000_0FFC, 4'h8, 1'b1);
      q_cnt = 0; preload(8, 3); base_req = n_req; base_ev = n_ev;
      wr_reg(2'd0, RUN); wait_cyc(80);
      chk(n_req - base_req == 4, "R7 stop at boundary", n_req - base_req, 4);
      chk(n_ev - base_ev == 1, "R7 one event", n_ev - base_ev, 1);
      chk(q_cnt == 4, "R8 bytes left while blocked", q_cnt, 4);
      wr_reg(2'd2, 32'h7); wait_cyc(30);
      chk(n_req - base_req == 4, "R8 high write keeps block", n_req - base_req, 4);
      wr_reg(2'd1, 32'h0000_2000); wait_cyc(60);
      chk(n_req - base_req == 8, "R8 low write restarts", n_req - base_req, 8);
      chk(n_ev - base_ev == 1, "R7 no extra event", n_ev - base_ev, 1);

      // R7 16 KiB boundary reading from memory
      setup(32'h3, 32'h0000_3FFA, 4'hA, 1'b0);
      q_cnt = 0; q_cap = 8; base_req = n_req; base_ev = n_ev;
      wr_reg(2'd0, RUN); wait_cyc(80);
      chk(n_req - base_req == 6, "R7 size 2 stop", n_req - base_req, 6);
      chk(n_ev - base_ev == 1, "R7 size 2 event", n_ev - base_ev, 1);
      q_cap = 64;

      // R7 check disabled
      setup(32'h0, 32'h0000_0FFE, 4'h7, 1'b1);
      q_cnt = 0; preload(4, 4); base_req = n_req; base_ev = n_ev;
      wr_reg(2'd0, RUN); wait_cyc(60);
      chk(n_req - base_req == 4, "R7 disabled no stop", n_req - base_req, 4);
      chk(n_ev == base_ev, "R7 disabled no event", n_ev - base_ev, 0);

      // random phase
      rnd_ready = 1'b1;
      void'($urandom(32'd4242));
      for (int it = 0; it < 12; it++) begin
         logic dir, en;
         int f, n;
         logic [63:0] mask, start;
         logic [31:0] lo, hi;
         dir  = 1'($urandom % 2);
         en   = 1'($urandom % 2);
         f    = int'($urandom % 3);
         n    = 1 + int'($urandom % 12);
         mask = (64'd1 << (12 + f)) - 64'd1;
         lo   = ($urandom & 32'hFFF0_0000) | (mask[31:0] - ($urandom % 16));
         hi   = $urandom;
         setup(hi, lo, {en, 3'(f)}, dir);
         start = {hi, lo};
         q_cnt = 0;
         if (dir) begin preload(n, it); q_cap = 64; end
         else q_cap = n;
         exp_n = 0; exp_blk = 1'b0;
         for (int i = 0; i < n && !exp_blk; i++) begin
            exp_n++;
            if (en && (((start + 64'(i)) & mask) == mask)) exp_blk = 1'b1;
         end
         base_req = n_req; base_ev = n_ev;
         wr_reg(2'd0, RUN); wait_cyc(200);
         chk(n_req - base_req == exp_n, "R7 R4 R5 random byte count", n_req - base_req, exp_n);
         chk(n_ev - base_ev == int'(exp_blk), "R7 random event", n_ev - base_ev, exp_blk);
         chk(q_cnt == (dir ? n - exp_n : exp_n), "R4 R5 random buffer level", q_cnt,
             dir ? n - exp_n : exp_n);
      end
      q_cap = 64;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule